// File: doc/BRIEF.md
# GPIO Interrupt Detect and Status Unit

This unit watches a bank of general-purpose input pins and turns pin activity into interrupt requests. Each pin passes through a two-stage synchronizer. It can then be armed for any mix of four trigger conditions: low level, high level, rising edge and falling edge. Arming both edge conditions on one pin gives detection on either edge. Each trigger is selected by its own read/write register, so the conditions on one pin combine freely.

Any detected event sets the pin's bit in the raw status of both interrupt lines. Each line has its own enable mask, changed only through a set alias and a clear alias; a written 1 acts on a bit and a written 0 leaves it alone. The masked status of a line is its raw status ANDed with its enable. The line's request output is the registered OR of that masked status. Software acknowledges an event by writing 1 to the line's status register. A level-triggered bit keeps coming back while its level is still present. An edge-triggered bit stays clear until a new edge arrives.

All registers sit behind a simple 32-bit register port. Writes take effect on the clock edge. Reads return data combinationally for the address presented.

Top module: `gpio_irq_unit`

## Requirements
- R1: Offset 0x000 reads 0x50600801 and ignores writes.
- R2: Offsets 0x140 (low-level), 0x144 (high-level), 0x148 (rising) and 0x14C (falling) are read/write detect selects, with bit n belonging to pin n.
- R3: A rising edge on a pin with its rising select set sets bit n of both raw status registers (0x024 line 0, 0x028 line 1), visible three clock edges after the pin changes.
- R4: A falling edge sets the raw bit when the falling select is set; with both edge selects set, either edge sets it.
- R5: While a pin is at a selected level (high select and pin 1, or low select and pin 0), its raw bit is set, and it remains set through an acknowledge until the level goes away.
- R6: An acknowledged edge-triggered bit stays 0 until a new qualifying edge occurs.
- R7: Writing 1s to 0x034/0x038 sets enable bits of line 0/1, and writing 1s to 0x03C/0x040 clears them; 0 bits leave enables unchanged; both aliases of a line read back its enable.
- R8: Raw status records events whatever the enable; 0x02C/0x030 read raw status ANDed with the line's enable.
- R9: Writing 1s to 0x02C/0x030 clears those raw bits of that line only; 0 bits have no effect.
- R10: irq_o[k] is high exactly when line k has any masked status bit set, and changes on the same edge as the status.
- R11: When an event and an acknowledge hit the same bit on the same edge, the bit ends up set.
- R12: After reset, all detect selects, enables, status bits and both request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| req_valid_i | input | 1 | Register access valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for req_addr_i |
| irq_o | output | 2 | Interrupt request per line |

## Verification
A wrong enable or detect-select bit shows up at the next register read. It also shows as a request output that either asserts or fails to assert three edges after a pin change. A status bit that drops while it should stay set, or stays set when it should drop, is visible on the next read of the raw or masked status. It also shows on irq_o on the very edge where the status changes. A stale previous-sample register shows up as a spurious or missing edge event within three edges of the pin stimulus.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned LINES  = 2;

    localparam logic [31:0] REV_ID = 32'h5060_0801;

    // register byte offsets (line 1 sits 4 bytes above line 0)
    localparam int unsigned OFS_REV      = 'h000;
    localparam int unsigned OFS_RAW      = 'h024;
    localparam int unsigned OFS_STAT     = 'h02C;
    localparam int unsigned OFS_EN_SET   = 'h034;
    localparam int unsigned OFS_EN_CLR   = 'h03C;
    localparam int unsigned OFS_DET_LOW  = 'h140;
    localparam int unsigned OFS_DET_HIGH = 'h144;
    localparam int unsigned OFS_DET_RISE = 'h148;
    localparam int unsigned OFS_DET_FALL = 'h14C;
    localparam int unsigned LINE_STRIDE  = 4;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.stage1 = async_i;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stage2;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp_i,
    input  logic [W-1:0] sel_low_i,
    input  logic [W-1:0] sel_high_i,
    input  logic [W-1:0] sel_rise_i,
    input  logic [W-1:0] sel_fall_i,
    output logic [W-1:0] evt_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = smp_i;
        evt_o  = (sel_low_i  & ~smp_i)
               | (sel_high_i &  smp_i)
               | (sel_rise_i &  smp_i & ~prev_q)
               | (sel_fall_i & ~smp_i &  prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         en_set_we_i,
    input  logic         en_clr_we_i,
    input  logic         ack_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] raw_o,
    output logic [W-1:0] en_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] raw;
        logic [W-1:0] en;
        logic         irq;
    } line_t;

    line_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (en_set_we_i) ln_d.en = ln_d.en | wdata_i;
        if (en_clr_we_i) ln_d.en = ln_d.en & ~wdata_i;
        if (ack_we_i)    ln_d.raw = ln_d.raw & ~wdata_i;
        // a new event overrides a same-edge acknowledge
        ln_d.raw = ln_d.raw | evt_i;
        ln_d.irq = |(ln_d.raw & ln_d.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign raw_o = ln_q.raw;
    assign en_o  = ln_q.en;
    assign irq_o = ln_q.irq;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                req_valid_i,
    input  logic                req_write_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic [DATA_W-1:0]   req_wdata_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic [LINES-1:0]    irq_o
);
    localparam int unsigned W = NUM_PINS;

    typedef struct packed {
        logic [W-1:0] low;
        logic [W-1:0] high;
        logic [W-1:0] rise;
        logic [W-1:0] fall;
    } det_t;

    det_t det_d, det_q;

    logic                    wr;
    logic [W-1:0]            wdata;
    logic [W-1:0]            smp;
    logic [W-1:0]            evt;
    logic [LINES-1:0]        en_set_we;
    logic [LINES-1:0]        en_clr_we;
    logic [LINES-1:0]        ack_we;
    logic [LINES-1:0][W-1:0] raw_all;
    logic [LINES-1:0][W-1:0] en_all;

    assign wr    = req_valid_i & req_write_i;
    assign wdata = req_wdata_i[W-1:0];

    gpio_irq_sync #(.W(W)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (smp)
    );

    gpio_irq_detect #(.W(W)) detect_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_i      (smp),
        .sel_low_i  (det_q.low),
        .sel_high_i (det_q.high),
        .sel_rise_i (det_q.rise),
        .sel_fall_i (det_q.fall),
        .evt_o      (evt)
    );

    for (genvar k = 0; k < LINES; k++) begin : g_line
        localparam int unsigned OFS = k * LINE_STRIDE;

        assign en_set_we[k] = wr && (req_addr_i == ADDR_W'(OFS_EN_SET + OFS));
        assign en_clr_we[k] = wr && (req_addr_i == ADDR_W'(OFS_EN_CLR + OFS));
        assign ack_we[k]    = wr && (req_addr_i == ADDR_W'(OFS_STAT + OFS));

        gpio_irq_line #(.W(W)) line_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .evt_i       (evt),
            .en_set_we_i (en_set_we[k]),
            .en_clr_we_i (en_clr_we[k]),
            .ack_we_i    (ack_we[k]),
            .wdata_i     (wdata),
            .raw_o       (raw_all[k]),
            .en_o        (en_all[k]),
            .irq_o       (irq_o[k])
        );
    end

    // detect-select registers
    always_comb begin
        det_d = det_q;
        if (wr) begin
            unique case (req_addr_i)
                ADDR_W'(OFS_DET_LOW):  det_d.low  = wdata;
                ADDR_W'(OFS_DET_HIGH): det_d.high = wdata;
                ADDR_W'(OFS_DET_RISE): det_d.rise = wdata;
                ADDR_W'(OFS_DET_FALL): det_d.fall = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    // read path
    logic [W-1:0] rd_pins;
    logic         rd_rev;

    always_comb begin
        rd_pins = '0;
        rd_rev  = 1'b0;
        unique case (req_addr_i)
            ADDR_W'(OFS_REV):                    rd_rev  = 1'b1;
            ADDR_W'(OFS_RAW):                    rd_pins = raw_all[0];
            ADDR_W'(OFS_RAW + LINE_STRIDE):      rd_pins = raw_all[1];
            ADDR_W'(OFS_STAT):                   rd_pins = raw_all[0] & en_all[0];
            ADDR_W'(OFS_STAT + LINE_STRIDE):     rd_pins = raw_all[1] & en_all[1];
            ADDR_W'(OFS_EN_SET),
            ADDR_W'(OFS_EN_CLR):                 rd_pins = en_all[0];
            ADDR_W'(OFS_EN_SET + LINE_STRIDE),
            ADDR_W'(OFS_EN_CLR + LINE_STRIDE):   rd_pins = en_all[1];
            ADDR_W'(OFS_DET_LOW):                rd_pins = det_q.low;
            ADDR_W'(OFS_DET_HIGH):               rd_pins = det_q.high;
            ADDR_W'(OFS_DET_RISE):               rd_pins = det_q.rise;
            ADDR_W'(OFS_DET_FALL):               rd_pins = det_q.fall;
            default: ;
        endcase
        rd_data_o = '0;
        rd_data_o[W-1:0] = rd_pins;
        if (rd_rev) rd_data_o = REV_ID;
    end
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned ADDR_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       req_addr_i,
    input logic [DATA_W-1:0]       rd_data_o,
    input logic [W-1:0]            evt,
    input logic [W-1:0]            wdata,
    input logic [LINES-1:0]        en_set_we,
    input logic [LINES-1:0]        en_clr_we,
    input logic [LINES-1:0]        ack_we,
    input logic [LINES-1:0][W-1:0] raw_all,
    input logic [LINES-1:0][W-1:0] en_all,
    input logic [LINES-1:0]        irq_o
);
    // R1
    rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr_i == '0) |-> (rd_data_o == REV_ID));

    for (genvar k = 0; k < LINES; k++) begin : g_chk
        // R10
        irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[k] == |(raw_all[k] & en_all[k]));

        // R9
        ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ack_we[k] |=> ((raw_all[k] & $past(wdata) & ~$past(evt)) == '0));

        // R11
        event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((raw_all[k] & $past(evt)) == $past(evt)));

        // R7
        en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(en_set_we[k] || en_clr_we[k]) |=> $stable(en_all[k]));

        // R8
        raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ack_we[k] |=> ((raw_all[k] & $past(raw_all[k])) == $past(raw_all[k])));
    end
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.W(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_addr_i (req_addr_i),
    .rd_data_o  (rd_data_o),
    .evt        (evt),
    .wdata      (wdata),
    .en_set_we  (en_set_we),
    .en_clr_we  (en_clr_we),
    .ack_we     (ack_we),
    .raw_all    (raw_all),
    .en_all     (en_all),
    .irq_o      (irq_o)
);

// File: tb/gpio_irq_unit_tb_top.sv
module gpio_irq_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NV         = 64;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_PN = 2'd2;
    localparam logic [1:0] OP_IQ = 2'd3;

    // entry = {req[3:0], op[1:0], addr[11:0], data[31:0]}
    localparam logic [49:0] VEC [NV] = '{
        {4'd1,  OP_RD, 12'h000, 32'h5060_0801}, // R1 revision
        {4'd1,  OP_WR, 12'h000, 32'hFFFF_FFFF}, // R1 write ignored
        {4'd1,  OP_RD, 12'h000, 32'h5060_0801}, // R1
        {4'd2,  OP_WR, 12'h148, 32'h0000_000F}, // R2 rising select pins 0..3
        {4'd2,  OP_RD, 12'h148, 32'h0000_000F}, // R2
        {4'd7,  OP_WR, 12'h034, 32'h0000_0003}, // R7 set enables line 0
        {4'd7,  OP_RD, 12'h034, 32'h0000_0003}, // R7
        {4'd7,  OP_RD, 12'h03C, 32'h0000_0003}, // R7 clear alias reads enable
        {4'd7,  OP_WR, 12'h038, 32'h0000_0004}, // R7 line 1
        {4'd7,  OP_RD, 12'h038, 32'h0000_0004}, // R7
        {4'd3,  OP_PN, 12'h000, 32'h0000_0005}, // R3 rise on pins 0,2
        {4'd3,  OP_RD, 12'h024, 32'h0000_0005}, // R3
        {4'd3,  OP_RD, 12'h028, 32'h0000_0005}, // R3
        {4'd8,  OP_RD, 12'h02C, 32'h0000_0001}, // R8 masked line 0
        {4'd8,  OP_RD, 12'h030, 32'h0000_0004}, // R8 masked line 1
        {4'd10, OP_IQ, 12'h000, 32'h0000_0003}, // R10
        {4'd9,  OP_WR, 12'h02C, 32'h0000_0001}, // R9 ack pin 0 line 0
        {4'd9,  OP_RD, 12'h024, 32'h0000_0004}, // R9
        {4'd9,  OP_RD, 12'h028, 32'h0000_0005}, // R9 other line untouched
        {4'd7,  OP_WR, 12'h03C, 32'h0000_0000}, // R7 zero write
        {4'd7,  OP_RD, 12'h034, 32'h0000_0003}, // R7
        {4'd7,  OP_WR, 12'h03C, 32'h0000_0001}, // R7 clear bit 0
        {4'd7,  OP_RD, 12'h034, 32'h0000_0002}, // R7
        {4'd9,  OP_WR, 12'h02C, 32'h0000_0000}, // R9 zero ack
        {4'd9,  OP_RD, 12'h024, 32'h0000_0004}, // R9
        {4'd2,  OP_WR, 12'h144, 32'h0000_0100}, // R2 high select pin 8
        {4'd2,  OP_WR, 12'h14C, 32'h0000_0010}, // R2 falling select pin 4
        {4'd2,  OP_RD, 12'h144, 32'h0000_0100}, // R2
        {4'd5,  OP_PN, 12'h000, 32'h0000_0115}, // R5 pin 8 high
        {4'd4,  OP_PN, 12'h000, 32'h0000_0105}, // R4 pin 4 falls
        {4'd4,  OP_RD, 12'h024, 32'h0000_0114}, // R4
        {4'd4,  OP_RD, 12'h028, 32'h0000_0115}, // R4
        {4'd11, OP_WR, 12'h02C, 32'h0000_0100}, // R11 ack while level held
        {4'd11, OP_RD, 12'h024, 32'h0000_0114}, // R11
        {4'd5,  OP_PN, 12'h000, 32'h0000_0005}, // R5 level removed
        {4'd5,  OP_WR, 12'h02C, 32'h0000_0100}, // R5
        {4'd5,  OP_RD, 12'h024, 32'h0000_0014}, // R5
        {4'd6,  OP_WR, 12'h02C, 32'h0000_0010}, // R6 ack edge bit
        {4'd6,  OP_PN, 12'h000, 32'h0000_0005}, // R6 no new edge
        {4'd6,  OP_RD, 12'h024, 32'h0000_0004}, // R6
        {4'd8,  OP_RD, 12'h02C, 32'h0000_0000}, // R8
        {4'd10, OP_IQ, 12'h000, 32'h0000_0002}, // R10
        {4'd5,  OP_WR, 12'h140, 32'h0000_1000}, // R5 low select pin 12
        {4'd5,  OP_PN, 12'h000, 32'h0000_0005}, // R5
        {4'd5,  OP_RD, 12'h024, 32'h0000_1004}, // R5
        {4'd9,  OP_WR, 12'h140, 32'h0000_0000}, // R9 prep
        {4'd9,  OP_WR, 12'h02C, 32'hFFFF_FFFF}, // R9
        {4'd9,  OP_WR, 12'h030, 32'hFFFF_FFFF}, // R9
        {4'd9,  OP_RD, 12'h024, 32'h0000_0000}, // R9
        {4'd9,  OP_RD, 12'h028, 32'h0000_0000}, // R9
        {4'd10, OP_IQ, 12'h000, 32'h0000_0000}, // R10
        {4'd7,  OP_WR, 12'h038, 32'h0000_0001}, // R7
        {4'd3,  OP_PN, 12'h000, 32'h0000_0004}, // R3
        {4'd3,  OP_PN, 12'h000, 32'h0000_0005}, // R3 rise pin 0
        {4'd3,  OP_RD, 12'h024, 32'h0000_0001}, // R3
        {4'd8,  OP_RD, 12'h030, 32'h0000_0001}, // R8
        {4'd8,  OP_RD, 12'h02C, 32'h0000_0000}, // R8 enable 0 masks it
        {4'd10, OP_IQ, 12'h000, 32'h0000_0002}, // R10
        {4'd10, OP_WR, 12'h034, 32'h0000_0001}, // R10 unmask
        {4'd10, OP_IQ, 12'h000, 32'h0000_0003}, // R10
        {4'd4,  OP_WR, 12'h14C, 32'h0000_0011}, // R4 both edges pin 0
        {4'd4,  OP_WR, 12'h02C, 32'hFFFF_FFFF}, // R4
        {4'd4,  OP_PN, 12'h000, 32'h0000_0004}, // R4 fall pin 0
        {4'd4,  OP_RD, 12'h024, 32'h0000_0001}  // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_i = '0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [11:0] req_addr_i = '0;
    logic [31:0] req_wdata_i = '0;
    logic [31:0] rd_data_o;
    logic [1:0]  irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin_i),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .rd_data_o   (rd_data_o),
        .irq_o       (irq_o)
    );

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_wdata_i = d;
        @(negedge clk);
        req_valid_i = 1'b0; req_write_i = 1'b0;
    endtask

    task automatic bus_read_chk(input int req, input logic [11:0] a, input logic [31:0] e);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a;
        #1;
        check(req, $sformatf("read %h", a), rd_data_o, e);
        req_valid_i = 1'b0;
    endtask

    task automatic set_pins(input logic [31:0] p);
        @(negedge clk);
        pin_i = p;
        repeat (4) @(negedge clk);
    endtask

    task automatic irq_chk(input int req, input logic [1:0] e);
        @(negedge clk);
        check(req, "irq_o", {30'd0, irq_o}, {30'd0, e});
    endtask

    task automatic reset_chk();
        // R12 everything cleared
        bus_read_chk(12, 12'h024, 32'h0);
        bus_read_chk(12, 12'h028, 32'h0);
        bus_read_chk(12, 12'h034, 32'h0);
        bus_read_chk(12, 12'h038, 32'h0);
        bus_read_chk(12, 12'h140, 32'h0);
        bus_read_chk(12, 12'h148, 32'h0);
        irq_chk(12, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reset_chk();

        for (int i = 0; i < NV; i++) begin
            logic [49:0] v;
            v = VEC[i];
            case (v[45:44])
                OP_WR: bus_write(v[43:32], v[31:0]);
                OP_RD: bus_read_chk(int'(v[49:46]), v[43:32], v[31:0]);
                OP_PN: set_pins(v[31:0]);
                default: irq_chk(int'(v[49:46]), v[1:0]);
            endcase
        end

        // R12 reset mid-run with state present
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pin_i = '0;
        reset_chk();

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule